// File: doc/BRIEF.md
# Configuration Readback Sequencer

This block is the host side of a configuration readback over a byte-wide parallel configuration port. After one start pulse it writes a fixed script of 32-bit words to the device, one byte per clock. The script does the following in order: pads and detects the bus width, synchronizes, shuts the device down, resets its CRC, selects read-configuration mode, sets the starting frame address, and requests a frame-data read sized for the requested frames. It then sends a NOOP flush and turns the port around to read.

While reading, the block samples a byte only in cycles where the device reports not busy. It packs four bytes into a word and forwards only the real frame words on a valid/data stream. Two kinds of word are dropped: the dummy frame that the device's frame buffer emits first, and the trailing extra word caused by the byte-wide port. Finally it writes a restart script, desynchronizes, and keeps sending NOOPs until the device reports configuration done. If done does not arrive within a bounded number of cycles, it gives up and flags a timeout.

Frame size, frame count, starting address, timeout and byte order are parameters.

Top module: `cfg_readback_seq`

## Requirements
- R1: While in reset and when idle, `cs_n_o` is 1 and `bus_oe_o`, `rdwr_o`, `word_valid_o`, `seq_done_o` and `timeout_o` are 0.
- R2: A `start_i` pulse seen while idle begins the sequence. In the next cycle `cs_n_o` is 0. Every script word goes out most significant byte first, one byte per clock, with `bus_oe_o` 1 and `rdwr_o` 0.
- R3: The pre-read script is exactly 56 words, in this order:
  - FFFFFFFF, 000000BB, 11220044, FFFFFFFF, AA995566, 20000000;
  - 30008001, 0000000B, 20000000 (shutdown);
  - 30008001, 00000007 (CRC reset), then six 20000000;
  - 30008001, 00000004, 20000000 (read-configuration mode);
  - 30002001, then the `FRAME_ADDR` word;
  - 28006000, then the sized read header;
  - 32 words of 20000000.
- R4: The sized read header equals 48000000 OR'ed with N in bits 26:0, where N = WORDS_PER_FRAME*(FRAMES+1)+1 (4800000D at the defaults 4 and 2).
- R5: After the last pre-read byte, `rdwr_o` is 1 and `bus_oe_o` is 0. A byte of `bus_i` is taken only at a clock edge where `busy_i` is 0. Exactly 4*N bytes are taken before writing resumes.
- R6: Each group of four taken bytes forms one word, the first byte taken being the most significant. A kept word appears on `word_data_o` with `word_valid_o` high for one cycle, in the cycle after its fourth byte is taken.
- R7: Of the N words read, the first WORDS_PER_FRAME and the last one are dropped. Exactly WORDS_PER_FRAME*FRAMES words are presented, in read order.
- R8: The post-read script is exactly 11 words, in this order:
  - 20000000;
  - 30008001, 00000005 (start), 20000000;
  - 30008001, 00000007, 20000000;
  - 30008001, 0000000D (desynchronize);
  - two 20000000.
- R9: After the post-read script, NOOP (20000000) bytes continue until `dev_done_i` is seen high at an edge. The next cycle has `seq_done_o` high for exactly one cycle and the block idle.
- R10: If `dev_done_i` stays low for DONE_TIMEOUT clock edges of that waiting phase, the block goes idle with `seq_done_o` pulsed and `timeout_o` set. `timeout_o` holds until the next accepted start clears it.
- R11: `start_i` has no effect while a sequence is running: the written byte stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one port byte per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a readback sequence when idle |
| cs_n_o | output | 1 | Port chip select, active low |
| rdwr_o | output | 1 | Port direction: 0 write, 1 read |
| bus_oe_o | output | 1 | Host drives `bus_o` onto the shared byte bus |
| bus_o | output | 8 | Byte driven to the device |
| bus_i | input | 8 | Byte returned by the device |
| busy_i | input | 1 | Device not ready; read byte invalid |
| dev_done_i | input | 1 | Device configuration-done level |
| word_valid_o | output | 1 | `word_data_o` holds a kept frame word |
| word_data_o | output | 32 | Captured frame word |
| seq_done_o | output | 1 | One-cycle pulse at end of the sequence |
| timeout_o | output | 1 | Done never arrived; sticky until next start |

## Verification
The assertions assume that `busy_i` and `bus_i` are settled before each rising edge. They also assume that `dev_done_i` matters only during the waiting phase and that the bus is not otherwise contended. The stimulus changes every input on the falling edge. It drives read bytes only while `rdwr_o` is high and advances to the next byte only after a cycle where busy was low. It raises done only after the restart script has fully gone out, and lowers it before each new start. The busy patterns used are never-busy, irregular, and every-other-cycle stalls. A start pulse is also issued in the middle of a sequence.

// File: rtl/cfg_rb_pkg.sv
package cfg_rb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_READ,
      ST_POST,
      ST_WAIT
   } seq_st_e;

   localparam logic [31:0] W_PAD      = 32'hFFFF_FFFF;
   localparam logic [31:0] W_WID_SYNC = 32'h0000_00BB;
   localparam logic [31:0] W_WID_DET  = 32'h1122_0044;
   localparam logic [31:0] W_SYNC     = 32'hAA99_5566;
   localparam logic [31:0] W_NOOP     = 32'h2000_0000;
   localparam logic [31:0] H_CMD_WR   = 32'h3000_8001;
   localparam logic [31:0] H_ADDR_WR  = 32'h3000_2001;
   localparam logic [31:0] H_DATA_RD  = 32'h2800_6000;
   localparam logic [31:0] H_LONG_RD  = 32'h4800_0000;

   localparam logic [31:0] OP_SHUT    = 32'h0000_000B;
   localparam logic [31:0] OP_CRCRST  = 32'h0000_0007;
   localparam logic [31:0] OP_RDCFG   = 32'h0000_0004;
   localparam logic [31:0] OP_START   = 32'h0000_0005;
   localparam logic [31:0] OP_DESYNC  = 32'h0000_000D;

   localparam int PRE_WORDS   = 56;
   localparam int POST_WORDS  = 11;
   localparam int IDX_W       = $clog2(PRE_WORDS);
   localparam int COUNT_BITS  = 27;

endpackage

// File: rtl/cfg_rb_script.sv
module cfg_rb_script
   import cfg_rb_pkg::*;
#(
   parameter int          WORDS_PER_FRAME = 4,
   parameter int          FRAMES          = 2,
   parameter logic [31:0] FRAME_ADDR      = 32'h0
) (
   input  logic             post_i,
   input  logic             fill_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [31:0]      word_o
);
   localparam int          READ_WORDS = WORDS_PER_FRAME * (FRAMES + 1) + 1;
   localparam logic [31:0] READ_CNT   = READ_WORDS;
   localparam logic [31:0] LONG_HDR   = H_LONG_RD | {5'd0, READ_CNT[COUNT_BITS-1:0]};

   logic [31:0] pre_w;
   logic [31:0] post_w;

   always_comb begin
      case (idx_i)
         6'd0:    pre_w = W_PAD;
         6'd1:    pre_w = W_WID_SYNC;
         6'd2:    pre_w = W_WID_DET;
         6'd3:    pre_w = W_PAD;
         6'd4:    pre_w = W_SYNC;
         6'd6:    pre_w = H_CMD_WR;
         6'd7:    pre_w = OP_SHUT;
         6'd9:    pre_w = H_CMD_WR;
         6'd10:   pre_w = OP_CRCRST;
         6'd17:   pre_w = H_CMD_WR;
         6'd18:   pre_w = OP_RDCFG;
         6'd20:   pre_w = H_ADDR_WR;
         6'd21:   pre_w = FRAME_ADDR;
         6'd22:   pre_w = H_DATA_RD;
         6'd23:   pre_w = LONG_HDR;
         default: pre_w = W_NOOP;
      endcase
   end

   always_comb begin
      case (idx_i)
         6'd1, 6'd4, 6'd7: post_w = H_CMD_WR;
         6'd2:             post_w = OP_START;
         6'd5:             post_w = OP_CRCRST;
         6'd8:             post_w = OP_DESYNC;
         default:          post_w = W_NOOP;
      endcase
   end

   assign word_o = fill_i ? W_NOOP : (post_i ? post_w : pre_w);

endmodule

// File: rtl/cfg_rb_serializer.sv
module cfg_rb_serializer #(
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [31:0] word_i,
   input  logic [1:0]  sel_i,
   output logic [7:0]  byte_o
);
   generate
      if (MSB_FIRST) begin : g_msb
         assign byte_o = word_i[8*(3-sel_i) +: 8];
      end else begin : g_lsb
         assign byte_o = word_i[8*sel_i +: 8];
      end
   endgenerate
endmodule

// File: rtl/cfg_rb_capture.sv
module cfg_rb_capture #(
   parameter int WORDS_PER_FRAME = 4,
   parameter int FRAMES          = 2,
   parameter bit MSB_FIRST       = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        en_i,
   input  logic [7:0]  byte_i,
   output logic        valid_o,
   output logic [31:0] data_o,
   output logic        fin_o
);
   localparam int READ_WORDS = WORDS_PER_FRAME * (FRAMES + 1) + 1;
   localparam int CW         = $clog2(READ_WORDS + 1);
   localparam int KEEP_LO    = WORDS_PER_FRAME;
   localparam int KEEP_HI    = WORDS_PER_FRAME * (FRAMES + 1);

   logic [CW-1:0] rd_cnt;
   logic [1:0]    bcnt;
   logic [31:0]   sh;
   logic [31:0]   sh_nx;
   logic          word_end;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_nx = {sh[23:0], byte_i};
      end else begin : g_lsb
         assign sh_nx = {byte_i, sh[31:8]};
      end
   endgenerate

   assign word_end = en_i && (bcnt == 2'd3);
   assign fin_o    = word_end && (rd_cnt == CW'(READ_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt  <= '0;
         bcnt    <= '0;
         sh      <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else if (clr_i) begin
         rd_cnt  <= '0;
         bcnt    <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (en_i) begin
            sh   <= sh_nx;
            bcnt <= bcnt + 2'd1;
            if (word_end) begin
               data_o  <= sh_nx;
               valid_o <= (rd_cnt >= CW'(KEEP_LO)) && (rd_cnt < CW'(KEEP_HI));
               rd_cnt  <= rd_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cfg_readback_seq.sv
module cfg_readback_seq
   import cfg_rb_pkg::*;
#(
   parameter int          WORDS_PER_FRAME = 4,
   parameter int          FRAMES          = 2,
   parameter logic [31:0] FRAME_ADDR      = 32'h0,
   parameter int          DONE_TIMEOUT    = 64,
   parameter bit          MSB_FIRST       = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   output logic        cs_n_o,
   output logic        rdwr_o,
   output logic        bus_oe_o,
   output logic [7:0]  bus_o,
   input  logic [7:0]  bus_i,
   input  logic        busy_i,
   input  logic        dev_done_i,
   output logic        word_valid_o,
   output logic [31:0] word_data_o,
   output logic        seq_done_o,
   output logic        timeout_o
);
   localparam int TW = $clog2(DONE_TIMEOUT + 1);

   generate
      if (WORDS_PER_FRAME < 1 || FRAMES < 1) begin : g_bad_size
         $error("cfg_readback_seq: frame size and count must be at least 1");
      end
      if (WORDS_PER_FRAME * (FRAMES + 1) + 1 >= (1 << COUNT_BITS)) begin : g_bad_count
         $error("cfg_readback_seq: read length does not fit the count field");
      end
      if (DONE_TIMEOUT < 1) begin : g_bad_to
         $error("cfg_readback_seq: DONE_TIMEOUT must be at least 1");
      end
   endgenerate

   seq_st_e          st;
   logic [IDX_W-1:0] widx;
   logic [1:0]       bidx;
   logic [TW-1:0]    to_cnt;
   logic             go;
   logic             cap_en;
   logic             cap_fin;
   logic [31:0]      cur_word;
   logic             word_last_byte;

   assign go             = (st == ST_IDLE) && start_i;
   assign cap_en         = (st == ST_READ) && !busy_i;
   assign word_last_byte = (bidx == 2'd3);

   cfg_rb_script #(
      .WORDS_PER_FRAME (WORDS_PER_FRAME),
      .FRAMES          (FRAMES),
      .FRAME_ADDR      (FRAME_ADDR)
   ) u_script (
      .post_i (st == ST_POST),
      .fill_i (st == ST_WAIT),
      .idx_i  (widx),
      .word_o (cur_word)
   );

   cfg_rb_serializer #(
      .MSB_FIRST (MSB_FIRST)
   ) u_ser (
      .word_i (cur_word),
      .sel_i  (bidx),
      .byte_o (bus_o)
   );

   cfg_rb_capture #(
      .WORDS_PER_FRAME (WORDS_PER_FRAME),
      .FRAMES          (FRAMES),
      .MSB_FIRST       (MSB_FIRST)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (go),
      .en_i    (cap_en),
      .byte_i  (bus_i),
      .valid_o (word_valid_o),
      .data_o  (word_data_o),
      .fin_o   (cap_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         widx       <= '0;
         bidx       <= '0;
         to_cnt     <= '0;
         seq_done_o <= 1'b0;
         timeout_o  <= 1'b0;
      end else begin
         seq_done_o <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start_i) begin
                  st        <= ST_PRE;
                  widx      <= '0;
                  bidx      <= '0;
                  timeout_o <= 1'b0;
               end
            end
            ST_PRE: begin
               bidx <= bidx + 2'd1;
               if (word_last_byte) begin
                  if (widx == IDX_W'(PRE_WORDS - 1)) begin
                     st   <= ST_READ;
                     widx <= '0;
                  end else begin
                     widx <= widx + 1'b1;
                  end
               end
            end
            ST_READ: begin
               if (cap_fin) begin
                  st   <= ST_POST;
                  widx <= '0;
                  bidx <= '0;
               end
            end
            ST_POST: begin
               bidx <= bidx + 2'd1;
               if (word_last_byte) begin
                  if (widx == IDX_W'(POST_WORDS - 1)) begin
                     st     <= ST_WAIT;
                     widx   <= '0;
                     to_cnt <= '0;
                  end else begin
                     widx <= widx + 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               bidx <= bidx + 2'd1;
               if (dev_done_i) begin
                  st         <= ST_IDLE;
                  seq_done_o <= 1'b1;
               end else if (to_cnt == TW'(DONE_TIMEOUT - 1)) begin
                  st         <= ST_IDLE;
                  seq_done_o <= 1'b1;
                  timeout_o  <= 1'b1;
               end else begin
                  to_cnt <= to_cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign cs_n_o   = (st == ST_IDLE);
   assign rdwr_o   = (st == ST_READ);
   assign bus_oe_o = (st == ST_PRE) || (st == ST_POST) || (st == ST_WAIT);

endmodule

// File: rtl/cfg_rb_checker.sv
module cfg_rb_checker #(
   parameter int KEEP_WORDS = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n_o,
   input logic       rdwr_o,
   input logic       bus_oe_o,
   input logic       busy_i,
   input logic       word_valid_o,
   input logic       seq_done_o,
   input logic       timeout_o
);
   localparam int KW = $clog2(KEEP_WORDS + 2);
   logic [KW-1:0] kept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           kept <= '0;
      else if (cs_n_o)      kept <= '0;
      else if (word_valid_o) kept <= kept + 1'b1;
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> (!bus_oe_o && !rdwr_o && !word_valid_o));

   assert_write_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && !rdwr_o) |-> bus_oe_o);

   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rdwr_o |-> !bus_oe_o);

   assert_busy_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rdwr_o && busy_i) |-> !word_valid_o);

   assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> $past(rdwr_o && !busy_i));

   assert_keep_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      kept <= KW'(KEEP_WORDS));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done_o |=> !seq_done_o);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done_o |-> cs_n_o);

   assert_timeout_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> seq_done_o);
endmodule

bind cfg_readback_seq cfg_rb_checker #(
   .KEEP_WORDS (WORDS_PER_FRAME * FRAMES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n_o       (cs_n_o),
   .rdwr_o       (rdwr_o),
   .bus_oe_o     (bus_oe_o),
   .busy_i       (busy_i),
   .word_valid_o (word_valid_o),
   .seq_done_o   (seq_done_o),
   .timeout_o    (timeout_o)
);

// File: tb/sim_cfg_readback_seq.sv
module sim_cfg_readback_seq;
   localparam int CLK_PERIOD = 10;
   localparam int WPF        = 4;
   localparam int FR         = 2;
   localparam int TO         = 64;
   localparam int NRD        = WPF * (FR + 1) + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cs_n_o, rdwr_o, bus_oe_o;
   logic [7:0]  bus_o;
   logic [7:0]  bus_i = 8'h00;
   logic        busy_i = 1'b0;
   logic        dev_done_i = 1'b0;
   logic        word_valid_o;
   logic [31:0] word_data_o;
   logic        seq_done_o, timeout_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_readback_seq #(
      .WORDS_PER_FRAME (WPF),
      .FRAMES          (FR),
      .FRAME_ADDR      (32'h0),
      .DONE_TIMEOUT    (TO),
      .MSB_FIRST       (1'b1)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .cs_n_o (cs_n_o), .rdwr_o (rdwr_o), .bus_oe_o (bus_oe_o),
      .bus_o (bus_o), .bus_i (bus_i), .busy_i (busy_i),
      .dev_done_i (dev_done_i), .word_valid_o (word_valid_o),
      .word_data_o (word_data_o), .seq_done_o (seq_done_o),
      .timeout_o (timeout_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [31:0] wq[$];
   logic [31:0] rq[$];

   int run_id = 0, busy_mode = 0, done_dly = 0;
   int cyc = 0, nb = 0, rb = 0, wait_bytes = 0, kept = 0, exp_wait = 0;
   bit sd_seen = 0, armed = 0;
   logic [31:0] acc = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_word(input int run, input int k);
      return {8'hA0 + 8'(run), 8'(k), 8'h5C, ~8'(k)};
   endfunction

   // driver: expected write stream pushed into the scoreboard queue
   task automatic push_script();
      wq.delete();
      wq.push_back(32'hFFFFFFFF); wq.push_back(32'h000000BB);
      wq.push_back(32'h11220044); wq.push_back(32'hFFFFFFFF);
      wq.push_back(32'hAA995566); wq.push_back(32'h20000000);
      wq.push_back(32'h30008001); wq.push_back(32'h0000000B); wq.push_back(32'h20000000);
      wq.push_back(32'h30008001); wq.push_back(32'h00000007);
      for (int i = 0; i < 6; i++) wq.push_back(32'h20000000);
      wq.push_back(32'h30008001); wq.push_back(32'h00000004); wq.push_back(32'h20000000);
      wq.push_back(32'h30002001); wq.push_back(32'h00000000);
      wq.push_back(32'h28006000);
      wq.push_back(32'h48000000 | 32'(NRD));   // R4: 4800000D
      for (int i = 0; i < 32; i++) wq.push_back(32'h20000000);
      // post-read part R8
      wq.push_back(32'h20000000);
      wq.push_back(32'h30008001); wq.push_back(32'h00000005); wq.push_back(32'h20000000);
      wq.push_back(32'h30008001); wq.push_back(32'h00000007); wq.push_back(32'h20000000);
      wq.push_back(32'h30008001); wq.push_back(32'h0000000D);
      wq.push_back(32'h20000000); wq.push_back(32'h20000000);
   endtask

   // monitor and device model
   always @(negedge clk) begin
      cyc++;
      if (rst_n && armed) begin
         if (word_valid_o) begin
            if (rq.size() == 0) chk(0, "R7 extra word", word_data_o, 32'h0);
            else chk(word_data_o == rq.pop_front(), "R6 R7 word", word_data_o, word_data_o);
            kept++;
         end
         if (seq_done_o) begin
            sd_seen = 1;
            chk(wait_bytes == exp_wait, "R9 R10 wait length", 32'(wait_bytes), 32'(exp_wait));
            chk(cs_n_o == 1'b1, "R9 idle at done", 32'(cs_n_o), 32'h1);
         end
         if (!cs_n_o && bus_oe_o) begin
            chk(rdwr_o == 1'b0, "R2 write direction", 32'(rdwr_o), 32'h0);
            if (wq.size() == 0) wait_bytes++;
            acc = {acc[23:0], bus_o};
            nb++;
            if (nb == 4) begin
               nb = 0;
               if (wq.size() == 0) chk(acc == 32'h20000000, "R9 trailing noop", acc, 32'h20000000);
               else begin
                  logic [31:0] e;
                  e = wq.pop_front();
                  chk(acc == e, "R3 R4 R8 script word", acc, e);
               end
            end
            if (done_dly > 0 && wait_bytes >= done_dly) dev_done_i = 1'b1;
         end
         if (cs_n_o) nb = 0;
         if (rdwr_o) begin
            chk(bus_oe_o == 1'b0, "R5 read turnaround", 32'(bus_oe_o), 32'h0);
            case (busy_mode)
               1:       busy_i = ((cyc % 5) == 2) || ((cyc % 7) == 0);
               2:       busy_i = cyc[0];
               default: busy_i = 1'b0;
            endcase
            if (!busy_i) begin
               logic [31:0] w;
               w = rd_word(run_id, rb / 4);
               bus_i = w[8*(3 - (rb % 4)) +: 8];
               rb++;
               if ((rb % 4) == 0 && (rb/4 - 1) >= WPF && (rb/4 - 1) < WPF*(FR+1))
                  rq.push_back(w);
            end else begin
               bus_i = 8'hEE;
            end
         end else begin
            busy_i = 1'b0;
         end
      end
   end

   task automatic run_seq(input int id, input int bmode, input int ddly, input bit exp_to);
      run_id = id; busy_mode = bmode; done_dly = ddly;
      exp_wait = (ddly > 0) ? ddly : TO;
      wait_bytes = 0; rb = 0; kept = 0; nb = 0; sd_seen = 0;
      dev_done_i = 1'b0;
      rq.delete();
      push_script();
      armed = 1;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(cs_n_o == 1'b0, "R2 start accepted", 32'(cs_n_o), 32'h0);
      chk(timeout_o == 1'b0, "R10 cleared by start", 32'(timeout_o), 32'h0);
      if (id == 1) begin
         repeat (30) @(negedge clk);
         start_i = 1'b1;               // R11: ignored mid-sequence
         @(negedge clk); start_i = 1'b0;
      end
      wait (sd_seen);
      @(negedge clk);
      chk(seq_done_o == 1'b0, "R9 single pulse", 32'(seq_done_o), 32'h0);
      chk(wq.size() == 0, "R3 R8 R11 script complete", 32'(wq.size()), 32'h0);
      chk(rb == 4*NRD, "R5 bytes taken", 32'(rb), 32'(4*NRD));
      chk(kept == WPF*FR, "R7 kept words", 32'(kept), 32'(WPF*FR));
      chk(rq.size() == 0, "R7 nothing missing", 32'(rq.size()), 32'h0);
      chk(timeout_o == exp_to, "R10 timeout flag", 32'(timeout_o), 32'(exp_to));
      repeat (5) @(negedge clk);
      chk(timeout_o == exp_to, "R10 flag held", 32'(timeout_o), 32'(exp_to));
      chk(cs_n_o == 1'b1 && bus_oe_o == 1'b0, "R1 idle after run", {cs_n_o, bus_oe_o}, 32'h2);
      armed = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1 && !bus_oe_o && !rdwr_o && !word_valid_o && !seq_done_o && !timeout_o,
          "R1 reset state", {cs_n_o, bus_oe_o, rdwr_o, word_valid_o, seq_done_o, timeout_o}, 32'h20);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n_o == 1'b1 && !bus_oe_o, "R1 idle after reset", {cs_n_o, bus_oe_o}, 32'h2);
      run_seq(1, 1, 10, 1'b0);
      run_seq(2, 2, 0, 1'b1);
      run_seq(3, 0, 3, 1'b0);
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule